// File: doc/BRIEF.md
# Dual-Queue Conversion Command Sequencer

This block steps through a 64-entry table of conversion command words on behalf of two queues. Queue 1 always begins at entry 0. Queue 2 begins at an index held in a 7-bit begin-pointer input, so it can also point past the table. When a queue is triggered, the sequencer reads command words one at a time. For each word it decides whether to start a conversion on an external converter or to end the queue. At the end it records completion and pause events in sticky flags, and it reports each queue as idle, active or paused.

Every command word is 16 bits wide. Bits [5:0] hold the channel number and bit 6 is the pause request. Channel value 63 is reserved as an end-of-queue marker. Several conditions end a queue:

- fetching the marker;
- fetching the last table entry after it has converted;
- queue 1 arriving at the index held by the queue 2 begin pointer;
- queue 2 being triggered with a pointer of 64 or more.

When more than one of these holds at once, they behave as a single end. A pause that is followed directly by an end of queue closes the queue instead of parking it. Only one queue runs at a time, and the analog side sits behind a start/done handshake.

Top module: `ccw_queue_seq`

## Requirements
- R1: After reset both completion flags and both pause flags are 0, both status outputs read idle (00), and neither convStart nor tblRd is asserted.
- R2: Queue 1 starts at entry 0 and queue 2 at beginPtr. Entries are read in ascending order: tblRd is high for one cycle with tblAddr, and tblData is valid in the next cycle. Each entry that does not end the queue produces one convStart pulse, with convChan equal to bits [5:0] of the entry. No further entry is read until convDone has been seen.
- R3: An entry whose channel field is 63 is read but not converted. It sets the queue's completion flag and returns the queue to idle, including when it is the first entry of a run.
- R4: Triggering queue 2 with beginPtr in 64..127 sets its completion flag and returns it to idle with no table read and no conversion.
- R5: Entry 63, when converted, ends the queue afterwards: completion is set and the status becomes idle. This includes queue 2 triggered with beginPtr equal to 63.
- R6: While queue 1 runs, reading the entry whose index equals beginPtr ends the queue without converting it. With beginPtr equal to 0, queue 1 reads entry 0 and converts nothing.
- R7: An entry with bit 6 set is converted normally. If the next position does not end the queue, the pause flag is set and the status becomes paused (10). The next trigger of that queue resumes at the following entry.
- R8: If a pause-marked entry is followed by an end-of-queue condition (the marker in the next entry, the pause on entry 63, or the next index equal to beginPtr during queue 1), both the pause flag and the completion flag are set and the status becomes idle.
- R9: While a queue is active (status 01), triggers for either queue are ignored. At most one queue is active at any time. When both triggers arrive together while no queue is running, queue 1 is taken and the queue 2 trigger is ignored.
- R10: Completion and pause flags stay set until a 1 is written on the matching bit of doneClr or pauseClr (bit 0 is queue 1, bit 1 is queue 2). Clearing one flag leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trig1 | input | 1 | Trigger for queue 1 |
| trig2 | input | 1 | Trigger for queue 2 |
| beginPtr | input | 7 | Queue 2 begin index (64..127 lies beyond the table) |
| doneClr | input | 2 | Write-one-to-clear for completion flags |
| pauseClr | input | 2 | Write-one-to-clear for pause flags |
| tblRd | output | 1 | Table read strobe |
| tblAddr | output | 6 | Table read index |
| tblData | input | 16 | Table read data, valid one cycle after tblRd |
| convStart | output | 1 | One-cycle conversion start |
| convChan | output | 6 | Channel for the conversion, valid with convStart |
| convDone | input | 1 | Conversion finished pulse |
| doneFlag | output | 2 | Sticky completion flags, bit 0 queue 1 |
| pauseFlag | output | 2 | Sticky pause flags, bit 0 queue 1 |
| q1Status | output | 2 | Queue 1 status: 00 idle, 01 active, 10 paused |
| q2Status | output | 2 | Queue 2 status: 00 idle, 01 active, 10 paused |

## Verification
The bench uses the default parameters: a 6-bit table index, 6-bit channels and 16-bit words. With these values the full 64-entry table and the whole 0..127 begin-pointer range can be reached. It sweeps beginPtr across both halves of that range, pairs it with several computed table patterns of markers and pause bits, and resumes every paused run until the queue closes. This brings the rare coincidences within reach: a marker at the begin pointer, a pause on entry 63, and a pause just before the begin pointer.

// File: rtl/ccwseq_pkg.sv
package ccwseq_pkg;

  typedef enum logic [1:0] {
    QS_IDLE   = 2'b00,
    QS_ACTIVE = 2'b01,
    QS_PAUSED = 2'b10
  } qStat_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;   // take a new run for whichQ
    logic whichQ;   // 0 = queue 1, 1 = queue 2
    logic finish;   // end the running queue
    logic park;     // pause the running queue
    logic issue;    // current entry goes to the converter
    logic advance;  // step to the next entry
  } seqStrb_t;

endpackage

// File: rtl/ccwseq_dp.sv
module ccwseq_dp
  import ccwseq_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int CH_W      = 6,
  parameter int CCW_W     = 16,
  parameter int PAUSE_POS = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrb_t               strb,
  input  logic [IDX_W:0]         beginPtr,
  input  logic [CCW_W-1:0]       tblData,
  input  logic [1:0]             doneClr,
  input  logic [1:0]             pauseClr,
  output logic [IDX_W-1:0]       tblAddr,
  output logic [CH_W-1:0]        chanOut,
  output logic                   startOut,
  output logic                   isEoq,
  output logic                   atEnd,
  output logic                   pendPause,
  output logic [1:0][1:0]        statVec,
  output logic [1:0]             doneFlag,
  output logic [1:0]             pauseFlag
);
  localparam int NQ = 2;
  localparam logic [CH_W-1:0] EOQ_CODE = {CH_W{1'b1}};

  logic [IDX_W:0]   curIdx;
  logic             curQ;
  logic [IDX_W:0]   startIdx;
  logic [IDX_W-1:0] resumeIdx [NQ];
  logic [CCW_W-1:0] unusedWord;

  assign unusedWord = tblData;
  assign chanOut    = tblData[CH_W-1:0];
  assign tblAddr    = curIdx[IDX_W-1:0];
  assign startOut   = curIdx[IDX_W];
  assign atEnd      = (curIdx[IDX_W-1:0] == {IDX_W{1'b1}});
  assign isEoq      = (chanOut == EOQ_CODE) || (!curQ && (curIdx == beginPtr));

  always_comb begin
    if (statVec[strb.whichQ] == QS_PAUSED)
      startIdx = {1'b0, resumeIdx[strb.whichQ]};
    else if (strb.whichQ)
      startIdx = beginPtr;
    else
      startIdx = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx    <= '0;
      curQ      <= 1'b0;
      pendPause <= 1'b0;
    end else begin
      if (strb.accept) begin
        curIdx    <= startIdx;
        curQ      <= strb.whichQ;
        pendPause <= 1'b0;
      end
      if (strb.issue)   pendPause <= tblData[PAUSE_POS];
      if (strb.advance) curIdx    <= curIdx + 1'b1;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    logic mine;
    assign mine = (curQ == 1'(q));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statVec[q]   <= QS_IDLE;
        resumeIdx[q] <= '0;
        doneFlag[q]  <= 1'b0;
        pauseFlag[q] <= 1'b0;
      end else begin
        if (strb.accept && strb.whichQ == 1'(q)) statVec[q] <= QS_ACTIVE;
        else if (strb.finish && mine)            statVec[q] <= QS_IDLE;
        else if (strb.park && mine)              statVec[q] <= QS_PAUSED;

        if (strb.park && mine) resumeIdx[q] <= curIdx[IDX_W-1:0];

        if (strb.finish && mine)  doneFlag[q] <= 1'b1;
        else if (doneClr[q])      doneFlag[q] <= 1'b0;

        if ((strb.finish && mine && pendPause) || (strb.park && mine))
          pauseFlag[q] <= 1'b1;
        else if (pauseClr[q])
          pauseFlag[q] <= 1'b0;
      end
    end

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (doneFlag[q] && !doneClr[q]) |=> doneFlag[q]);
    // R10
    pause_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pauseFlag[q] && !pauseClr[q]) |=> pauseFlag[q]);
  end

  // R9
  single_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(statVec[0] == QS_ACTIVE && statVec[1] == QS_ACTIVE));

  // R3
  no_marker_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> (chanOut != EOQ_CODE));

endmodule

// File: rtl/ccwseq_ctrl.sv
module ccwseq_ctrl
  import ccwseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     trig1,
  input  logic     trig2,
  input  logic     convDone,
  input  logic     startOut,
  input  logic     isEoq,
  input  logic     atEnd,
  input  logic     pendPause,
  output seqStrb_t strb,
  output logic     tblRd,
  output logic     convStart
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_FETCH, S_DECODE, S_WAIT} seqState_t;

  seqState_t state, nextState;

  always_comb begin
    strb      = '0;
    tblRd     = 1'b0;
    convStart = 1'b0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (trig1 || trig2) begin
          strb.accept = 1'b1;
          strb.whichQ = !trig1;
          nextState   = S_START;
        end
      end
      S_START: begin
        if (startOut) begin
          strb.finish = 1'b1;
          nextState   = S_IDLE;
        end else begin
          nextState = S_FETCH;
        end
      end
      S_FETCH: begin
        tblRd     = 1'b1;
        nextState = S_DECODE;
      end
      S_DECODE: begin
        if (isEoq) begin
          strb.finish = 1'b1;
          nextState   = S_IDLE;
        end else if (pendPause) begin
          strb.park = 1'b1;
          nextState = S_IDLE;
        end else begin
          strb.issue = 1'b1;
          convStart  = 1'b1;
          nextState  = S_WAIT;
        end
      end
      S_WAIT: begin
        if (convDone) begin
          if (atEnd) begin
            strb.finish = 1'b1;
            nextState   = S_IDLE;
          end else begin
            strb.advance = 1'b1;
            nextState    = S_FETCH;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  // R2
  no_fetch_in_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && !convDone) |=> !tblRd);
  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

endmodule

// File: rtl/ccw_queue_seq.sv
module ccw_queue_seq
  import ccwseq_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int CH_W      = 6,
  parameter int CCW_W     = 16,
  parameter int PAUSE_POS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trig1,
  input  logic             trig2,
  input  logic [IDX_W:0]   beginPtr,
  input  logic [1:0]       doneClr,
  input  logic [1:0]       pauseClr,
  output logic             tblRd,
  output logic [IDX_W-1:0] tblAddr,
  input  logic [CCW_W-1:0] tblData,
  output logic             convStart,
  output logic [CH_W-1:0]  convChan,
  input  logic             convDone,
  output logic [1:0]       doneFlag,
  output logic [1:0]       pauseFlag,
  output logic [1:0]       q1Status,
  output logic [1:0]       q2Status
);
  seqStrb_t        strb;
  logic            startOut, isEoq, atEnd, pendPause;
  logic [1:0][1:0] statVec;

  ccwseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .trig1(trig1), .trig2(trig2), .convDone(convDone),
    .startOut(startOut), .isEoq(isEoq), .atEnd(atEnd), .pendPause(pendPause),
    .strb(strb), .tblRd(tblRd), .convStart(convStart)
  );

  ccwseq_dp #(.IDX_W(IDX_W), .CH_W(CH_W), .CCW_W(CCW_W), .PAUSE_POS(PAUSE_POS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .beginPtr(beginPtr), .tblData(tblData),
    .doneClr(doneClr), .pauseClr(pauseClr), .tblAddr(tblAddr), .chanOut(convChan),
    .startOut(startOut), .isEoq(isEoq), .atEnd(atEnd), .pendPause(pendPause),
    .statVec(statVec), .doneFlag(doneFlag), .pauseFlag(pauseFlag)
  );

  assign q1Status = statVec[0];
  assign q2Status = statVec[1];

endmodule

// File: tb/ccw_queue_seq_tb.sv
module ccw_queue_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trig1 = 1'b0, trig2 = 1'b0;
  logic [6:0]  beginPtr = 7'd127;
  logic [1:0]  doneClr = 2'b00, pauseClr = 2'b00;
  logic        tblRd, convStart, convDone;
  logic [5:0]  tblAddr, convChan;
  logic [15:0] tblData;
  logic [1:0]  doneFlag, pauseFlag, q1Status, q2Status;

  always #2.5 clk = ~clk;

  ccw_queue_seq u_dut (
    .clk(clk), .rstN(rstN), .trig1(trig1), .trig2(trig2), .beginPtr(beginPtr),
    .doneClr(doneClr), .pauseClr(pauseClr), .tblRd(tblRd), .tblAddr(tblAddr),
    .tblData(tblData), .convStart(convStart), .convChan(convChan), .convDone(convDone),
    .doneFlag(doneFlag), .pauseFlag(pauseFlag), .q1Status(q1Status), .q2Status(q2Status)
  );

  // table with one cycle of read latency
  logic [15:0] mem [64];
  logic [15:0] tblQ = '0;
  always @(posedge clk) if (tblRd) tblQ <= mem[tblAddr];
  assign tblData = tblQ;

  // converter model: done two cycles after start; logs channels and reads
  int cd = 0, nConv = 0, nRd = 0;
  logic [5:0] convLog [8192];
  always @(posedge clk) begin
    if (tblRd) nRd <= nRd + 1;
    if (convStart) begin
      convLog[nConv % 8192] <= convChan;
      nConv <= nConv + 1;
      cd <= 2;
    end else if (cd != 0) cd <= cd - 1;
  end
  assign convDone = (cd == 1);

  int errors = 0, checks = 0;
  int expN, expDone, expPause, expStat;
  logic [5:0] expCh [64];
  bit mPaused [2];
  int mRes [2];

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference from the requirements
  task automatic model(input int q);
    int idx;
    bit pend;
    bit eoq;
    int ch;
    expN = 0; expDone = 0; expPause = 0; expStat = 0; pend = 0;
    if (mPaused[q]) idx = mRes[q];
    else idx = (q == 1) ? int'(beginPtr) : 0;
    mPaused[q] = 0;
    if (idx > 63) begin expDone = 1; return; end
    forever begin
      ch = int'(mem[idx][5:0]);
      eoq = (ch == 63) || (q == 0 && idx == int'(beginPtr));
      if (eoq) begin expDone = 1; expPause = pend; return; end
      if (pend) begin expPause = 1; expStat = 2; mPaused[q] = 1; mRes[q] = idx; return; end
      expCh[expN] = 6'(ch);
      expN++;
      pend = mem[idx][6];
      if (idx == 63) begin expDone = 1; expPause = pend; return; end
      idx++;
    end
  endtask

  function automatic int qStat(input int q);
    return (q == 0) ? int'(q1Status) : int'(q2Status);
  endfunction

  // run one trigger of queue q; poke = 1 sends extra triggers mid-run (R9)
  task automatic runQueue(input int q, input string req, input bit poke, output int reads);
    int baseC, baseR, mism, waitN;
    @(negedge clk); doneClr = 2'b11; pauseClr = 2'b11;
    @(negedge clk); doneClr = 2'b00; pauseClr = 2'b00;
    model(q);
    baseC = nConv; baseR = nRd;
    if (q == 0) trig1 = 1'b1; else trig2 = 1'b1;
    @(negedge clk); trig1 = 1'b0; trig2 = 1'b0;
    waitN = 0;
    while (qStat(q) == 1 && waitN < 3000) begin
      if (poke && waitN == 3) begin trig1 = 1'b1; trig2 = 1'b1; end
      @(negedge clk);
      trig1 = 1'b0; trig2 = 1'b0;
      if (poke) check("R9", "other queue status during run", qStat(1 - q), 0);
      waitN++;
    end
    mism = 0;
    for (int k = 0; k < expN; k++)
      if (k < nConv - baseC && convLog[(baseC + k) % 8192] != expCh[k]) mism++;
    check(req, "conversion count", nConv - baseC, expN);
    check(req, "channel mismatches (R2)", mism, 0);
    check(req, "completion flag", int'(doneFlag[q]), expDone);
    check(req, "pause flag", int'(pauseFlag[q]), expPause);
    check(req, "status", qStat(q), expStat);
    reads = nRd - baseR;
  endtask

  function automatic logic [15:0] patWord(input int pat, input int i);
    logic [15:0] w;
    w = '0;
    w[5:0] = 6'((i * 7 + pat * 13 + 5) % 63);
    if (pat != 0 && ((i + pat * 11) % 23) == 22) w[5:0] = 6'd63;
    w[6] = (((i * 3 + pat) % 17) == 4);
    w[15:7] = 9'(i * 5 + pat);
    return w;
  endfunction

  task automatic plainTable();
    for (int i = 0; i < 64; i++) mem[i] = {9'(i), 1'b0, 6'(i % 63)};
  endtask

  task automatic tests();
    int rd;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "doneFlag", int'(doneFlag), 0);
    check("R1", "pauseFlag", int'(pauseFlag), 0);
    check("R1", "q1Status", int'(q1Status), 0);
    check("R1", "q2Status", int'(q2Status), 0);
    check("R1", "convStart/tblRd", int'({convStart, tblRd}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 full queue 1 walk
    plainTable(); beginPtr = 7'd127;
    runQueue(0, "R2", 0, rd);
    check("R2", "reads for full walk", rd, 64);

    // R3 marker in first entry
    mem[0][5:0] = 6'd63;
    runQueue(0, "R3", 0, rd);
    check("R3", "entry read once", rd, 1);
    plainTable();

    // R5 queue 2 at entry 63
    beginPtr = 7'd63;
    runQueue(1, "R5", 0, rd);

    // R6 begin pointer zero stops queue 1 at entry 0
    beginPtr = 7'd0;
    runQueue(0, "R6", 0, rd);
    check("R6", "entry read once", rd, 1);

    // R4 pointer beyond the table
    beginPtr = 7'd100;
    runQueue(1, "R4", 0, rd);
    check("R4", "no table read", rd, 0);

    // R8 pause then marker
    plainTable(); beginPtr = 7'd127;
    mem[5][6] = 1'b1; mem[6][5:0] = 6'd63;
    runQueue(0, "R8", 0, rd);
    // R8 pause on entry 63
    plainTable(); mem[63][6] = 1'b1; beginPtr = 7'd60;
    runQueue(1, "R8", 0, rd);
    // R8 pause right before the begin pointer
    plainTable(); mem[20][6] = 1'b1; beginPtr = 7'd21;
    runQueue(0, "R8", 0, rd);

    // R7 pause and resume
    plainTable(); mem[3][6] = 1'b1; beginPtr = 7'd127;
    runQueue(0, "R7", 0, rd);
    runQueue(0, "R7", 0, rd);

    // R9 triggers during a run are ignored
    plainTable(); beginPtr = 7'd40;
    runQueue(0, "R9", 1, rd);
    // R9 simultaneous triggers: queue 1 wins
    @(negedge clk); trig1 = 1'b1; trig2 = 1'b1;
    @(negedge clk); trig1 = 1'b0; trig2 = 1'b0;
    check("R9", "q1 taken", int'(q1Status), 1);
    check("R9", "q2 ignored", int'(q2Status), 0);
    while (q1Status == 2'b01) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R9", "q2 never ran", int'(q2Status), 0);

    // R10 sticky flags and selective clear
    plainTable(); mem[10][6] = 1'b1; mem[11][5:0] = 6'd63; beginPtr = 7'd127;
    runQueue(0, "R10", 0, rd);
    repeat (5) @(negedge clk);
    check("R10", "done held", int'(doneFlag[0]), 1);
    check("R10", "pause held", int'(pauseFlag[0]), 1);
    doneClr = 2'b01;
    @(negedge clk); doneClr = 2'b00;
    check("R10", "done cleared", int'(doneFlag[0]), 0);
    check("R10", "pause untouched", int'(pauseFlag[0]), 1);
    pauseClr = 2'b10;
    @(negedge clk); pauseClr = 2'b00;
    check("R10", "other queue clear no effect", int'(pauseFlag[0]), 1);

    // sweep: patterns x begin pointers, resume until closed
    for (int pat = 0; pat < 4; pat++) begin
      for (int b = 0; b < 128; b += 9) begin
        for (int i = 0; i < 64; i++) mem[i] = patWord(pat, i);
        beginPtr = 7'(b);
        for (int q = 0; q < 2; q++) begin
          for (int n = 0; n < 70; n++) begin
            runQueue(q, "R7", 0, rd);
            if (!mPaused[q]) break;
          end
        end
      end
    end
  endtask

  initial begin
    mPaused[0] = 0; mPaused[1] = 0; mRes[0] = 0; mRes[1] = 0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    fork
      tests();
      begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule